// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog counter that software drives through two 16-bit registers on a simple synchronous bus. The bus has a write strobe, a one-bit address, write data, and combinational read data. Address 0 is the control word. Address 1 is the service port. The control word holds an 8-bit timeout code and six control bits. Once enabled, the counter counts down in half-second ticks. The tick length is set in clocks by the `TICK_CLKS` parameter, so a bench can use a small value. If the counter runs out, the block drives a reset output high for `PULSE_CLKS` clocks and then stops for good.

Software keeps the watchdog alive by writing two key words to the service port, 0x5555 and then 0xAAAA. Only the completed pair reloads the countdown. A timeout code n gives (n+1) ticks. A code written to the control word is only used at the next reload. Two freeze bits can hold the countdown while the debug-halt input is high, or while the low-power input is high.

The key checker has two states. In `KEY_IDLE`, a write of 0x5555 moves it to `KEY_ARMED`. In `KEY_ARMED`, a write of 0xAAAA issues a reload and returns to `KEY_IDLE`. Any other word returns it to `KEY_IDLE`. A further 0x5555 keeps it in `KEY_ARMED`.

The countdown core has four states:
- `CORE_OFF` goes to `CORE_COUNT` on enable, loading the code.
- `CORE_COUNT` reloads on a key pair. When the counter expires it goes to `CORE_FIRE` if reset-on-expiry is set, or to `CORE_HALT` if it is not.
- `CORE_FIRE` goes to `CORE_HALT` after the pulse.
- `CORE_HALT` is terminal.

A software-reset write moves `CORE_OFF` or `CORE_COUNT` straight to `CORE_FIRE`.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the control word reads 0xFF08, the service port reads 0x0000 and the reset output is low. While the enable bit is 0, the reset output never rises.
- R2: Control word layout: bits 15:8 timeout code, bit 0 low-power freeze, bit 1 debug freeze, bit 2 enable, bit 3 reset-on-expiry, bit 4 software reset (always reads 0), bit 5 expired flag (read-only), bits 7:6 read 0. Reads of the service port (address 1) return the key-armed state in bit 0.
- R3: If the enable bit is first set by a write at clock edge E with code n, the reset output rises at edge E + 1 + (n+1)·TICK_CLKS, provided no reload happens.
- R4: A write of 0x5555 followed later by a write of 0xAAAA to the service port is a service. If the 0xAAAA write lands at edge S, the countdown restarts and the reset output rises at edge S + (n+1)·TICK_CLKS, where n is the current code.
- R5: No reload happens for a lone 0xAAAA, or for a pair broken by any other service word. A service word other than 0x5555 or 0xAAAA clears the armed state.
- R6: Writing a new code does not change a running countdown. The code is used at the next service, and code 0 gives the minimum one-tick period.
- R7: Once set, the enable bit stays 1 until block reset, even if written with 0.
- R8: With the debug-freeze bit at 1, each clock with the debug-halt input high delays expiry by one clock. The low-power freeze bit works the same way with the low-power input. With the freeze bit at 0, the input has no effect.
- R9: On expiry with reset-on-expiry at 1, the reset output is high for exactly PULSE_CLKS (16) clocks and the expired flag sets. After that the output stays low, and services are ignored until block reset.
- R10: On expiry with reset-on-expiry at 0, no pulse appears, the expired flag sets, and the counter stops.
- R11: Writing 1 to the software-reset bit at edge E raises the reset output at edge E for PULSE_CLKS clocks, whether or not the block is enabled. The expired flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 service |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| dbg_halt | input | 1 | Debug-halt status |
| lp_mode | input | 1 | Low-power status |
| wdt_rst_out | output | 1 | Reset pulse output |

## Verification
The countdown is tried with several timeout codes, and each time the bench measures the exact edge at which the pulse rises. This separates the n+1 encoding and the one-clock enable latency from off-by-one faults. Service words are sent as a correct pair, a lone second key, a pair broken by a foreign word, and a pair issued after the code was changed. These show whether the reload depends on order, whether it is rejected when it should be, and whether the code is used late as required. Freeze inputs are pulsed with their enable bits set and with them clear, to tell a real hold from one that leaks through. The disabled, software-reset and no-reset-on-expiry runs each confirm that their pulse, or its absence, and the expired flag follow their own path.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 1;
    localparam int TOUT_W = 8;
    localparam int TOUT_LSB = 8;

    // Control word bit positions
    localparam int BIT_LPF = 0;
    localparam int BIT_DBGF = 1;
    localparam int BIT_EN = 2;
    localparam int BIT_EXPRST = 3;
    localparam int BIT_SWRST = 4;
    localparam int BIT_EXPIRED = 5;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_SVC = 1'b1;

    localparam logic [DATA_W-1:0] KEY_FIRST = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_SECOND = 16'hAAAA;

    localparam logic [TOUT_W-1:0] TOUT_RESET = 8'hFF;

    typedef enum logic {
        KEY_IDLE,
        KEY_ARMED
    } key_st_t;

    typedef enum logic [1:0] {
        CORE_OFF,
        CORE_COUNT,
        CORE_FIRE,
        CORE_HALT
    } core_st_t;
endpackage

// File: rtl/keyed_wdt_key.sv
module keyed_wdt_key
    import keyed_wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              svc_o,
    output logic              armed_o
);
    key_st_t st, nxt;
    logic    is_first, is_second;

    assign is_first  = (wdata_i == KEY_FIRST);
    assign is_second = (wdata_i == KEY_SECOND);

    always_comb begin
        nxt = st;
        if (wr_i) begin
            unique case (st)
                KEY_IDLE:  nxt = is_first ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: nxt = is_first ? KEY_ARMED : KEY_IDLE;
                default:   nxt = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= KEY_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        svc_o   = 1'b0;
        armed_o = 1'b0;
        unique case (st)
            KEY_IDLE:  armed_o = 1'b0;
            KEY_ARMED: begin
                armed_o = 1'b1;
                svc_o   = wr_i && is_second;
            end
            default:   armed_o = 1'b0;
        endcase
    end

    AST_KEY_PAIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        svc_o |=> !armed_o); // R4
    AST_KEY_FIRST_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && is_first) |=> armed_o); // R4
    AST_KEY_FOREIGN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !is_first && !is_second) |=> !armed_o); // R5
endmodule

// File: rtl/keyed_wdt_ctrl.sv
module keyed_wdt_ctrl
    import keyed_wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              expired_i,
    output logic [TOUT_W-1:0] tout_o,
    output logic              en_o,
    output logic              exp_rst_en_o,
    output logic              dbg_frz_o,
    output logic              lp_frz_o,
    output logic              sw_rst_o,
    output logic [DATA_W-1:0] rd_word_o
);
    logic [TOUT_W-1:0] tout_q;
    logic              en_q, exp_rst_q, dbg_q, lp_q;
    logic              unused_ctrl_bits;

    assign unused_ctrl_bits = ^wdata_i[7:6] ^ wdata_i[BIT_EXPIRED];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tout_q    <= TOUT_RESET;
            en_q      <= 1'b0;
            exp_rst_q <= 1'b1;
            dbg_q     <= 1'b0;
            lp_q      <= 1'b0;
        end else if (wr_i) begin
            tout_q    <= wdata_i[TOUT_LSB +: TOUT_W];
            en_q      <= en_q | wdata_i[BIT_EN];
            exp_rst_q <= wdata_i[BIT_EXPRST];
            dbg_q     <= wdata_i[BIT_DBGF];
            lp_q      <= wdata_i[BIT_LPF];
        end
    end

    always_comb begin
        tout_o       = tout_q;
        en_o         = en_q;
        exp_rst_en_o = exp_rst_q;
        dbg_frz_o    = dbg_q;
        lp_frz_o     = lp_q;
        sw_rst_o     = wr_i & wdata_i[BIT_SWRST];
        rd_word_o    = '0;
        rd_word_o[TOUT_LSB +: TOUT_W] = tout_q;
        rd_word_o[BIT_EXPIRED]        = expired_i;
        rd_word_o[BIT_EXPRST]         = exp_rst_q;
        rd_word_o[BIT_EN]             = en_q;
        rd_word_o[BIT_DBGF]           = dbg_q;
        rd_word_o[BIT_LPF]            = lp_q;
    end

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q); // R7
    AST_TOUT_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(tout_q)); // R6
endmodule

// File: rtl/keyed_wdt_core.sv
module keyed_wdt_core
    import keyed_wdt_pkg::*;
#(
    parameter int TICK_CLKS  = 16_000_000,
    parameter int PULSE_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [TOUT_W-1:0] tout_i,
    input  logic              exp_rst_en_i,
    input  logic              dbg_frz_i,
    input  logic              lp_frz_i,
    input  logic              dbg_halt_i,
    input  logic              lp_mode_i,
    input  logic              reload_i,
    input  logic              sw_rst_i,
    output logic              rst_o,
    output logic              expired_o
);
    localparam int PRE_W = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam int PCW   = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST   = PRE_W'(TICK_CLKS - 1);
    localparam logic [PCW-1:0]   PULSE_LAST = PCW'(PULSE_CLKS - 1);

    core_st_t          st, nxt;
    logic [PRE_W-1:0]  pre;
    logic [TOUT_W-1:0] cnt;
    logic [PCW-1:0]    pcnt;
    logic              expired_q;
    logic              frozen, tick, expire;

    assign frozen = (dbg_frz_i & dbg_halt_i) | (lp_frz_i & lp_mode_i);
    assign tick   = (st == CORE_COUNT) && !frozen && (pre == PRE_LAST);
    assign expire = tick && (cnt == '0) && !reload_i && !sw_rst_i;

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            CORE_OFF: begin
                if (sw_rst_i)  nxt = CORE_FIRE;
                else if (en_i) nxt = CORE_COUNT;
            end
            CORE_COUNT: begin
                if (sw_rst_i)    nxt = CORE_FIRE;
                else if (expire) nxt = exp_rst_en_i ? CORE_FIRE : CORE_HALT;
            end
            CORE_FIRE: begin
                if (pcnt == PULSE_LAST) nxt = CORE_HALT;
            end
            CORE_HALT: nxt = CORE_HALT;
            default:   nxt = CORE_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= CORE_OFF;
        else        st <= nxt;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre       <= '0;
            cnt       <= '0;
            pcnt      <= '0;
            expired_q <= 1'b0;
        end else begin
            unique case (st)
                CORE_OFF: begin
                    pcnt <= '0;
                    if (nxt == CORE_COUNT) begin
                        cnt <= tout_i;
                        pre <= '0;
                    end
                end
                CORE_COUNT: begin
                    pcnt <= '0;
                    if (expire) begin
                        expired_q <= 1'b1;
                    end else if (reload_i) begin
                        cnt <= tout_i;
                        pre <= '0;
                    end else if (!frozen) begin
                        if (pre == PRE_LAST) begin
                            pre <= '0;
                            cnt <= cnt - 1'b1;
                        end else begin
                            pre <= pre + 1'b1;
                        end
                    end
                end
                CORE_FIRE: pcnt <= pcnt + 1'b1;
                CORE_HALT: pcnt <= '0;
                default:   pcnt <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rst_o     = 1'b0;
        expired_o = expired_q;
        unique case (st)
            CORE_FIRE: rst_o = 1'b1;
            default:   rst_o = 1'b0;
        endcase
    end

    AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CORE_COUNT && nxt != CORE_COUNT && !sw_rst_i) |-> (cnt == '0 && pre == PRE_LAST)); // R3
    AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CORE_COUNT && reload_i && !sw_rst_i && !expire) |=> (cnt == $past(tout_i) && pre == '0)); // R4
    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CORE_COUNT && frozen && !reload_i && !sw_rst_i) |=> ($stable(cnt) && $stable(pre))); // R8
    AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CORE_FIRE && pcnt != PULSE_LAST) |=> rst_o); // R9
    AST_HALT_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CORE_HALT) |=> (st == CORE_HALT && !rst_o)); // R9
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int TICK_CLKS  = 16_000_000,
    parameter int PULSE_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_halt,
    input  logic              lp_mode,
    output logic              wdt_rst_out
);
    logic              ctrl_wr, svc_wr;
    logic              svc, armed;
    logic [TOUT_W-1:0] tout;
    logic              en, exp_rst_en, dbg_frz, lp_frz, sw_rst, expired;
    logic [DATA_W-1:0] ctrl_word;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign svc_wr  = bus_wr && (bus_addr == ADDR_SVC);

    keyed_wdt_key u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (svc_wr),
        .wdata_i (bus_wdata),
        .svc_o   (svc),
        .armed_o (armed)
    );

    keyed_wdt_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (ctrl_wr),
        .wdata_i      (bus_wdata),
        .expired_i    (expired),
        .tout_o       (tout),
        .en_o         (en),
        .exp_rst_en_o (exp_rst_en),
        .dbg_frz_o    (dbg_frz),
        .lp_frz_o     (lp_frz),
        .sw_rst_o     (sw_rst),
        .rd_word_o    (ctrl_word)
    );

    keyed_wdt_core #(
        .TICK_CLKS  (TICK_CLKS),
        .PULSE_CLKS (PULSE_CLKS)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .tout_i       (tout),
        .exp_rst_en_i (exp_rst_en),
        .dbg_frz_i    (dbg_frz),
        .lp_frz_i     (lp_frz),
        .dbg_halt_i   (dbg_halt),
        .lp_mode_i    (lp_mode),
        .reload_i     (svc),
        .sw_rst_i     (sw_rst),
        .rst_o        (wdt_rst_out),
        .expired_o    (expired)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_word;
            ADDR_SVC:  bus_rdata[0] = armed;
            default:   bus_rdata = '0;
        endcase
    end

    AST_NO_PULSE_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sw_rst && !wdt_rst_out) |=> !wdt_rst_out); // R1
endmodule

// File: tb/keyed_wdt_bench.sv
`timescale 1ns/1ps
module keyed_wdt_bench;
    localparam int TICK = 4;
    localparam int PULSE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [0:0]  bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        lp_mode = 1'b0;
    logic        wdt_rst_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        int    edge_no;
        string req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    keyed_wdt #(.TICK_CLKS(TICK), .PULSE_CLKS(PULSE)) u_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
        .lp_mode(lp_mode), .wdt_rst_out(wdt_rst_out)
    );

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    // Monitor: pops expected pulse edges and checks pulse width
    logic prev_out = 1'b0;
    int   hi_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_out = 1'b0;
            hi_cnt = 0;
        end else begin
            if (wdt_rst_out && !prev_out) begin
                if (sb.size() == 0) begin
                    chk("R1 unexpected pulse", cyc, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.req, " pulse start edge"}, cyc, e.edge_no);
                end
            end
            if (wdt_rst_out) hi_cnt++;
            if (!wdt_rst_out && prev_out) begin
                chk("R9 pulse width", hi_cnt, PULSE);
                hi_cnt = 0;
            end
            prev_out = wdt_rst_out;
        end
    end

    task automatic push_exp(input int e, input string req);
        exp_t x;
        x.edge_no = e;
        x.req = req;
        sb.push_back(x);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        dbg_halt = 1'b0;
        lp_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bwrite(input logic a, input logic [15:0] d, output int edge_o);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        edge_o = cyc;
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic service(output int s);
        int e;
        bwrite(1'b1, 16'h5555, e);
        bwrite(1'b1, 16'hAAAA, s);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drained(input string req);
        chk({req, " pending pulses"}, sb.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: actual hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int e, s;
        logic [15:0] rd;

        // R1 / R2: reset state and layout
        do_reset();
        bread(1'b0, rd); chk("R1 ctrl reset", rd, 16'hFF08);
        bread(1'b1, rd); chk("R2 service read", rd, 16'h0000);
        chk("R1 output low", wdt_rst_out, 0);
        idle(40);
        drained("R1");

        // R3 / R9: plain expiry, then halted
        do_reset();
        bwrite(1'b0, 16'h020C, e);
        push_exp(e + 1 + 3 * TICK, "R3");
        idle(40);
        drained("R3");
        bread(1'b0, rd); chk("R9 expired flag", rd, 16'h022C);
        service(s);
        idle(30);
        drained("R9 service after halt");

        // R4: repeated services keep it alive
        do_reset();
        bwrite(1'b0, 16'h030C, e);
        for (int i = 0; i < 3; i++) begin
            idle(6);
            service(s);
        end
        push_exp(s + 4 * TICK, "R4");
        idle(40);
        drained("R4");

        // R5: broken sequences do not reload
        do_reset();
        bwrite(1'b0, 16'h030C, e);
        push_exp(e + 1 + 4 * TICK, "R5");
        bwrite(1'b1, 16'hAAAA, s);
        bwrite(1'b1, 16'h5555, s);
        bread(1'b1, rd); chk("R5 armed after first key", rd, 16'h0001);
        bwrite(1'b1, 16'h1234, s);
        bread(1'b1, rd); chk("R5 armed cleared by foreign word", rd, 16'h0000);
        bwrite(1'b1, 16'hAAAA, s);
        idle(40);
        drained("R5");

        // R6 / R7: new code not used until service; enable sticky
        do_reset();
        bwrite(1'b0, 16'h050C, e);
        push_exp(e + 1 + 6 * TICK, "R6 old code kept");
        bwrite(1'b0, 16'h0008, s);
        bread(1'b0, rd); chk("R7 enable stays set", rd, 16'h000C);
        idle(50);
        drained("R6");

        // R6: minimum timeout path
        do_reset();
        bwrite(1'b0, 16'h050C, e);
        bwrite(1'b0, 16'h000C, e);
        service(s);
        push_exp(s + 1 * TICK, "R6 minimum");
        idle(30);
        drained("R6 minimum");

        // R8: debug freeze, low-power input ignored
        do_reset();
        bwrite(1'b0, 16'h030E, e);
        push_exp(e + 1 + 4 * TICK + 10, "R8 debug freeze");
        idle(1);
        @(negedge clk); dbg_halt = 1'b1;
        idle(10);
        dbg_halt = 1'b0; lp_mode = 1'b1;
        idle(5);
        lp_mode = 1'b0;
        idle(40);
        drained("R8 debug");

        // R8: low-power freeze, debug input ignored
        do_reset();
        bwrite(1'b0, 16'h030D, e);
        push_exp(e + 1 + 4 * TICK + 6, "R8 low-power freeze");
        idle(1);
        @(negedge clk); lp_mode = 1'b1;
        idle(6);
        lp_mode = 1'b0; dbg_halt = 1'b1;
        idle(4);
        dbg_halt = 1'b0;
        idle(40);
        drained("R8 low-power");

        // R10: expiry without reset
        do_reset();
        bwrite(1'b0, 16'h0204, e);
        idle(30);
        chk("R10 no pulse", wdt_rst_out, 0);
        bread(1'b0, rd); chk("R10 expired flag", rd, 16'h0224);
        service(s);
        idle(30);
        drained("R10");

        // R11: software reset while disabled
        do_reset();
        bwrite(1'b0, 16'h0010, e);
        push_exp(e, "R11");
        idle(25);
        drained("R11");
        bread(1'b0, rd); chk("R11 flag clear, bit reads 0", rd, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule